// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor read a serial NOR flash as if it were ordinary memory. Software first stores one control word that fixes the read command: the opcode, whether an opcode byte is sent at all, how many address bytes follow, how many data lines are used and how many dummy clocks come before the data. It then sets the window enable. While the window is enabled, every bus read at an offset starts one complete flash transaction. Chip select goes low, and the engine sends the opcode, then the offset as the address, then the dummy clocks. It then clocks in one data word and returns it on the bus with a one-cycle ready pulse.

The serial clock idles low. Data is driven while the clock is low and sampled on its rising edge. Each clock half lasts a fixed number of system clocks. Between two accesses, chip select stays high for at least one full serial clock period.

Top module: `flash_map_reader`

## Requirements
- R1: After reset, cs_n is high, sck is low, io_oe is 0, rd_ready is low and the window is disabled.
- R2: Register address 0 holds the control word, with these fields:
  - bits 31:24: opcode
  - bits 19:16: dummy clock count
  - bit 11: send-opcode flag
  - bits 10:8: address byte count, used as 0 to 4, with larger values treated as 4
  - bits 5:4: data lines, where 0 means 1 line, 1 means 2 lines and 2 means 4 lines
  - bits 3:0: flags that are stored but do not change the read sequence
- R3: Bit 0 written to register address 1 enables the window. A read while the window is disabled returns 0 with rd_ready in the next cycle, and cs_n stays high.
- R4: When the send-opcode flag is set, the opcode goes out first as 8 bits on io[0], most significant bit first, with io_oe = 0001. When the flag is clear, no opcode bits are sent.
- R5: The address is the window offset, zero-extended, sent most significant byte first. It uses the programmed data lines only for opcodes 0xBB, 0xEB, 0xBC and 0xEC. For all other opcodes it goes out on io[0] alone.
- R6: The dummy phase gives exactly the programmed number of sck rising edges with io_oe = 0. io_oe also stays 0 during the data phase.
- R7: The data phase takes DATA_W bits, most significant first within each byte:
  - on 2 or 4 lines, the highest line carries the more significant bit;
  - with 1 line, input is taken from io[1];
  - the first byte received lands in rd_data[7:0].
- R8: rd_ready stays low until the last data bit has been sampled. It then pulses high for one cycle, in the same cycle that cs_n is high again. The access has exactly opcode + address + dummy + data sck rising edges.
- R9: Between two accesses, cs_n stays high for at least 2*SCK_HALF clock cycles.
- R10: While the window is enabled, writes to register address 0 are ignored. A write to register address 1 is always accepted.
- R11: sck is low whenever cs_n is high, and every sck high phase lasts SCK_HALF clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 is the control word, 1 is the window enable |
| reg_wdata | input | 32 | Register write data |
| rd_req | input | 1 | Window read request, held until rd_ready |
| rd_offset | input | ADDR_W | Byte offset into the window |
| rd_ready | output | 1 | One-cycle pulse that marks rd_data valid |
| rd_data | output | DATA_W | Assembled read word |
| sck | output | 1 | Serial flash clock |
| cs_n | output | 1 | Flash chip select, active low |
| io_out | output | 4 | Serial data lines, outgoing |
| io_oe | output | 4 | Drive enable per data line |
| io_in | input | 4 | Serial data lines, incoming |

## Verification
The risky coincidence is a control-word write that lands in the same clock cycle in which a window read is accepted. The bench enables the window with a single-line plain read. In the same cycle it raises a read request and writes a quad I/O control word. The flash responder then checks the captured opcode, address lanes and edge count against the old shape, and the scoreboard checks the returned word. A second read, issued afterwards, must still show the old shape.

// File: rtl/flash_map_pkg.sv
package flash_map_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_GAP
  } fm_state_e;

  // Opcodes whose address phase uses the wide bus (I/O-style reads)
  function automatic logic addr_on_wide(input logic [7:0] opc);
    return (opc == 8'hBB) || (opc == 8'hEB) || (opc == 8'hBC) || (opc == 8'hEC);
  endfunction

  // Line-count code to log2 of lanes; reserved code 3 falls back to one line
  function automatic logic [1:0] lane_log2(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] lg);
    case (lg)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/fm_regs.sv
module fm_regs (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] ctl,
  output logic        map_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl    <= '0;
      map_en <= 1'b0;
    end else if (we) begin
      if (addr == 2'd1)
        map_en <= wdata[0];
      else if (addr == 2'd0 && !map_en)
        ctl <= wdata;
    end
  end

  // R10: control word frozen while window enabled
  a_r10_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    $past(map_en) |-> $stable(ctl));

endmodule

// File: rtl/fm_tick.sv
module fm_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == TW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (tick)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/fm_seq.sv
module fm_seq
  import flash_map_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int HALF   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              map_en,
  input  logic [7:0]        f_op,
  input  logic [3:0]        f_dummy,
  input  logic              f_cmd,
  input  logic [2:0]        f_nb,
  input  logic [1:0]        f_lines,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_offset,
  input  logic [3:0]        io_in,
  output logic              run,
  output logic              sck,
  output logic              cs_n,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe
);

  localparam int CNT_W = $clog2(((DATA_W > 32) ? DATA_W : 32) + 1);
  localparam int NBYTE = DATA_W / 8;
  localparam int GAP_W = $clog2(2 * HALF + 1);

  fm_state_e          st, tgt, after_cmd, after_addr;
  logic               ph, drv;
  logic [CNT_W-1:0]   cnt;
  logic [31:0]        sh;
  logic [1:0]         lg;
  logic [7:0]         l_op;
  logic               l_cmd;
  logic [2:0]         l_nb;
  logic [3:0]         l_dummy;
  logic [1:0]         l_dlg, l_alg;
  logic [31:0]        l_addr;
  logic [DATA_W-1:0]  rx, rx_next, swapped;

  logic [31:0]        ent_sh;
  logic [1:0]         ent_lg;
  logic               ent_drv;
  logic [CNT_W-1:0]   ent_cnt;

  // Next phase and its load values
  always_comb begin
    after_addr = (l_dummy != 4'd0) ? ST_DUMMY : ST_DATA;
    after_cmd  = (l_nb != 3'd0) ? ST_ADDR : after_addr;
    case (st)
      ST_LOAD: tgt = l_cmd ? ST_CMD : after_cmd;
      ST_CMD:  tgt = after_cmd;
      ST_ADDR: tgt = after_addr;
      default: tgt = ST_DATA;
    endcase
    ent_sh  = sh;
    ent_lg  = lg;
    ent_drv = 1'b0;
    ent_cnt = '0;
    case (tgt)
      ST_CMD: begin
        ent_sh  = {l_op, 24'h0};
        ent_lg  = 2'd0;
        ent_drv = 1'b1;
        ent_cnt = CNT_W'(8);
      end
      ST_ADDR: begin
        ent_sh  = l_addr << {(3'd4 - l_nb), 3'b000};
        ent_lg  = l_alg;
        ent_drv = 1'b1;
        ent_cnt = CNT_W'({l_nb, 3'b000} >> l_alg);
      end
      ST_DUMMY: ent_cnt = CNT_W'(l_dummy);
      default: begin
        ent_lg  = l_dlg;
        ent_cnt = CNT_W'(DATA_W >> l_dlg);
      end
    endcase
  end

  always_comb begin
    case (lg)
      2'd0:    rx_next = {rx[DATA_W-2:0], io_in[1]};
      2'd1:    rx_next = {rx[DATA_W-3:0], io_in[1:0]};
      default: rx_next = {rx[DATA_W-5:0], io_in[3:0]};
    endcase
  end

  // First received byte lands in the lowest byte lane
  always_comb begin
    for (int i = 0; i < NBYTE; i++)
      swapped[8*i +: 8] = rx[DATA_W-8-8*i +: 8];
  end

  always_comb begin
    case (lg)
      2'd0:    io_out = {3'b000, sh[31]};
      2'd1:    io_out = {2'b00, sh[31:30]};
      default: io_out = sh[31:28];
    endcase
  end

  assign io_oe = drv ? lane_mask(lg) : 4'b0000;
  assign run   = (st == ST_CMD) || (st == ST_ADDR) || (st == ST_DUMMY) ||
                 (st == ST_DATA) || (st == ST_GAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= 1'b0;
      drv      <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      lg       <= 2'd0;
      sck      <= 1'b0;
      cs_n     <= 1'b1;
      rd_ready <= 1'b0;
      rd_data  <= '0;
      rx       <= '0;
      l_op     <= '0;
      l_cmd    <= 1'b0;
      l_nb     <= '0;
      l_dummy  <= '0;
      l_dlg    <= '0;
      l_alg    <= '0;
      l_addr   <= '0;
    end else begin
      rd_ready <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (rd_req && !rd_ready) begin
            if (map_en) begin
              l_op    <= f_op;
              l_cmd   <= f_cmd;
              l_nb    <= (f_nb > 3'd4) ? 3'd4 : f_nb;
              l_dummy <= f_dummy;
              l_dlg   <= lane_log2(f_lines);
              l_alg   <= addr_on_wide(f_op) ? lane_log2(f_lines) : 2'd0;
              l_addr  <= 32'(rd_offset);
              st      <= ST_LOAD;
            end else begin
              rd_ready <= 1'b1;
              rd_data  <= '0;
            end
          end
        end
        ST_LOAD: begin
          st   <= tgt;
          sh   <= ent_sh;
          lg   <= ent_lg;
          drv  <= ent_drv;
          cnt  <= ent_cnt;
          cs_n <= 1'b0;
          ph   <= 1'b0;
        end
        ST_GAP: begin
          if (tick) begin
            if (cnt == CNT_W'(1)) st <= ST_IDLE;
            else                  cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (tick) begin
            if (!ph) begin
              sck <= 1'b1;
              ph  <= 1'b1;
              if (st == ST_DATA) rx <= rx_next;
            end else begin
              sck <= 1'b0;
              ph  <= 1'b0;
              if (cnt == CNT_W'(1)) begin
                if (st == ST_DATA) begin
                  st       <= ST_GAP;
                  cs_n     <= 1'b1;
                  drv      <= 1'b0;
                  rd_ready <= 1'b1;
                  rd_data  <= swapped;
                  cnt      <= CNT_W'(2);
                end else begin
                  st  <= tgt;
                  sh  <= ent_sh;
                  lg  <= ent_lg;
                  drv <= ent_drv;
                  cnt <= ent_cnt;
                end
              end else begin
                cnt <= cnt - 1'b1;
                sh  <= sh << (3'd1 << lg);
              end
            end
          end
        end
      endcase
    end
  end

  // Assertion support: cycles cs_n has been high, saturating
  logic [GAP_W-1:0] cs_hi;
  always_ff @(posedge clk) begin
    if (rst)
      cs_hi <= GAP_W'(2 * HALF);
    else if (!cs_n)
      cs_hi <= '0;
    else if (cs_hi != GAP_W'(2 * HALF))
      cs_hi <= cs_hi + 1'b1;
  end

  // R9: chip select high long enough between accesses
  a_r9_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (cs_hi >= GAP_W'(2 * HALF)));

  // R8: ready is a single-cycle pulse
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_ready |=> !rd_ready);

  // R11: clock idles low outside an access
  a_r11_sck_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  // R8: ready coincides with chip select released
  a_r8_ready_cs: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> cs_n);

endmodule

// File: rtl/flash_map_reader.sv
module flash_map_reader #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int SCK_HALF  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_offset,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);

  logic [31:0] ctl;
  logic        map_en;
  logic        run, tick;
  logic        ctl_unused;

  // Stored flag bits have no effect on the sequence
  assign ctl_unused = ^{ctl[23:20], ctl[15:12], ctl[7:6], ctl[3:0]};

  fm_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .ctl    (ctl),
    .map_en (map_en)
  );

  fm_tick #(.HALF(SCK_HALF)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  fm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF(SCK_HALF)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .map_en    (map_en),
    .f_op      (ctl[31:24]),
    .f_dummy   (ctl[19:16]),
    .f_cmd     (ctl[11]),
    .f_nb      (ctl[10:8]),
    .f_lines   (ctl[5:4]),
    .rd_req    (rd_req),
    .rd_offset (rd_offset),
    .io_in     (io_in),
    .run       (run),
    .sck       (sck),
    .cs_n      (cs_n),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .io_out    (io_out),
    .io_oe     (io_oe)
  );

endmodule

// File: tb/flash_map_reader_bench.sv
module flash_map_reader_bench;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rd_req = 1'b0;
  logic [23:0] rd_offset = '0;
  logic        rd_ready;
  logic [31:0] rd_data;
  logic        sck, cs_n;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = '0;

  flash_map_reader #(.ADDR_W(24), .DATA_W(32), .SCK_HALF(HALF)) u_flash_map_reader (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_req(rd_req), .rd_offset(rd_offset), .rd_ready(rd_ready), .rd_data(rd_data),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_tag = "R7";

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // Expected command shape (bench model)
  logic [7:0] e_op;
  bit         e_cmd;
  int         e_nb, e_w, e_aw, e_dummy;
  bit         bench_en = 0;
  int         cs_falls = 0;

  function automatic logic [7:0] fb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {fb(a + 3), fb(a + 2), fb(a + 1), fb(a)};
  endfunction

  function automatic bit wide_op(input logic [7:0] o);
    return (o == 8'hBB) || (o == 8'hEB) || (o == 8'hBC) || (o == 8'hEC);
  endfunction

  // Flash responder
  int          rise_cnt = 0;
  logic [7:0]  cap_op;
  logic [31:0] cap_addr, exp_addr;
  int          oe_bad = 0;
  bit          acc_active = 0;
  bit          had_access = 0;
  int          t_csrise = 0, t_sckrise = 0, sck_bad = 0;

  function automatic int cmd_bt();  return e_cmd ? 8 : 0; endfunction
  function automatic int addr_bt(); return e_nb * 8 / e_aw; endfunction
  function automatic int pre_bt();  return cmd_bt() + addr_bt() + e_dummy; endfunction

  always @(negedge cs_n) begin
    if (had_access)
      chk((cyc - t_csrise) >= 2 * HALF, "R9 cs gap", 64'(cyc - t_csrise), 64'(2 * HALF));
    rise_cnt = 0; cap_op = 0; cap_addr = 0; oe_bad = 0;
    acc_active = 1; cs_falls++;
  end

  always @(posedge sck) begin
    rise_cnt++;
    t_sckrise = cyc;
    if (rise_cnt <= cmd_bt()) begin
      cap_op = {cap_op[6:0], io_out[0]};
      if (io_oe !== 4'b0001) oe_bad++;
    end else if (rise_cnt <= cmd_bt() + addr_bt()) begin
      if (e_aw == 1)      begin cap_addr = {cap_addr[30:0], io_out[0]};   if (io_oe !== 4'b0001) oe_bad++; end
      else if (e_aw == 2) begin cap_addr = {cap_addr[29:0], io_out[1:0]}; if (io_oe !== 4'b0011) oe_bad++; end
      else                begin cap_addr = {cap_addr[27:0], io_out[3:0]}; if (io_oe !== 4'b1111) oe_bad++; end
    end else begin
      if (io_oe !== 4'b0000) oe_bad++;
    end
  end

  always @(negedge sck) begin
    if (cyc - t_sckrise != HALF) sck_bad++;
    if (rise_cnt >= pre_bt() && rise_cnt - pre_bt() < 32 / e_w) begin
      automatic int j = rise_cnt - pre_bt();
      automatic logic [31:0] s = {fb(cap_addr), fb(cap_addr + 1), fb(cap_addr + 2), fb(cap_addr + 3)};
      if (e_w == 1)      io_in = {2'b00, s[31 - j], 1'b0};
      else if (e_w == 2) io_in = {2'b00, s[31 - 2*j -: 2]};
      else               io_in = s[31 - 4*j -: 4];
    end
  end

  always @(posedge cs_n) begin
    if (acc_active) begin
      acc_active = 0; had_access = 1; t_csrise = cyc;
      chk(rise_cnt == pre_bt() + 32 / e_w, "R8 sck edges per access", 64'(rise_cnt), 64'(pre_bt() + 32 / e_w));
      if (e_cmd) chk(cap_op == e_op, "R4 opcode bits", 64'(cap_op), 64'(e_op));
      chk(cap_addr == exp_addr, "R5 address", 64'(cap_addr), 64'(exp_addr));
      chk(oe_bad == 0, "R6 drive enables per phase", 64'(oe_bad), 64'd0);
    end
  end

  // Scoreboard monitor
  logic [31:0] sb_q[$];
  always @(negedge clk) begin
    if (!rst && rd_ready === 1'b1) begin
      if (sb_q.size() == 0) begin
        chk(0, "R8 unexpected ready", 64'(rd_data), 64'd0);
      end else begin
        automatic logic [31:0] e = sb_q.pop_front();
        chk(rd_data === e, cur_tag, 64'(rd_data), 64'(e));
        chk(cs_n === 1'b1, "R8 cs_n high at ready", 64'(cs_n), 64'd1);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  function automatic logic [31:0] mk(input logic [7:0] op, input bit cmd, input logic [2:0] nb,
                                      input logic [1:0] wc, input logic [3:0] dm, input logic [3:0] fl);
    return {op, 4'h0, dm, 4'h0, cmd, nb, 2'b00, wc, fl};
  endfunction

  task automatic set_model(input logic [7:0] op, input bit cmd, input int nb, input logic [1:0] wc, input int dm);
    e_op = op; e_cmd = cmd; e_nb = nb; e_dummy = dm;
    e_w  = (wc == 2'd1) ? 2 : (wc == 2'd2) ? 4 : 1;
    e_aw = wide_op(op) ? e_w : 1;
  endtask

  task automatic cfg(input logic [7:0] op, input bit cmd, input int nb, input logic [1:0] wc,
                     input int dm, input logic [3:0] fl);
    wr(2'd1, 32'h0);
    wr(2'd0, mk(op, cmd, 3'(nb), wc, 4'(dm), fl));
    wr(2'd1, 32'h1);
    bench_en = 1;
    set_model(op, cmd, nb, wc, dm);
  endtask

  task automatic do_read(input logic [23:0] off, output int lat);
    exp_addr = 32'(off);
    sb_q.push_back(bench_en ? word_at(32'(off)) : 32'h0);
    @(negedge clk); rd_req = 1; rd_offset = off;
    lat = 0;
    do begin @(negedge clk); lat++; end while (rd_ready !== 1'b1);
    rd_req = 0;
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, f0;
    e_op = 0; e_cmd = 1; e_nb = 3; e_w = 1; e_aw = 1; e_dummy = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n === 1'b1, "R1 cs_n", 64'(cs_n), 64'd1);
    chk(sck === 1'b0, "R1 sck", 64'(sck), 64'd0);
    chk(io_oe === 4'b0, "R1 io_oe", 64'(io_oe), 64'd0);
    chk(rd_ready === 1'b0, "R1 rd_ready", 64'(rd_ready), 64'd0);

    // R3 disabled window: zero, next cycle, no chip select (also shows R1 disabled)
    cur_tag = "R3 disabled data"; f0 = cs_falls;
    do_read(24'h000040, lat);
    chk(lat == 1, "R3 disabled latency", 64'(lat), 64'd1);
    chk(cs_falls == f0, "R3 no cs activity", 64'(cs_falls), 64'(f0));

    // R7 plain read, one line
    cur_tag = "R7 plain read";
    cfg(8'h03, 1, 3, 2'd0, 0, 4'h1);
    do_read(24'h000100, lat);
    // R2 flag bits set, fast read with dummy: flags have no effect
    cur_tag = "R2 fast read with flags";
    cfg(8'h0B, 1, 3, 2'd0, 8, 4'hD);
    do_read(24'h0012A7, lat);
    // R7 dual output: address single line
    cur_tag = "R7 dual output";
    cfg(8'h3B, 1, 3, 2'd1, 8, 4'h1);
    do_read(24'h03C0DE, lat);
    // R5 dual I/O: address on two lines
    cur_tag = "R5 dual io";
    cfg(8'hBB, 1, 3, 2'd1, 4, 4'h1);
    do_read(24'hABCDEF, lat);
    // R7 quad output
    cur_tag = "R7 quad output";
    cfg(8'h6B, 1, 3, 2'd2, 8, 4'h1);
    do_read(24'h5A5A50, lat);
    // R5 quad I/O
    cur_tag = "R5 quad io";
    cfg(8'hEB, 1, 3, 2'd2, 6, 4'h1);
    do_read(24'h765432, lat);
    // R5 four-byte address, quad I/O
    cur_tag = "R5 four-byte quad io";
    cfg(8'hEC, 1, 4, 2'd2, 6, 4'h1);
    do_read(24'h123456, lat);
    // R5 four-byte address, single line
    cur_tag = "R5 four-byte plain";
    cfg(8'h13, 1, 4, 2'd0, 0, 4'h1);
    do_read(24'hFEDCB8, lat);
    // R4 opcode phase omitted
    cur_tag = "R4 no opcode";
    cfg(8'h0B, 0, 3, 2'd0, 2, 4'h1);
    do_read(24'h00F00F, lat);

    // R10 control write in the same cycle as a window read
    cfg(8'h03, 1, 3, 2'd0, 0, 4'h1);
    cur_tag = "R10 same-cycle write ignored";
    exp_addr = 32'h000224;
    sb_q.push_back(word_at(32'h000224));
    @(negedge clk);
    reg_we = 1; reg_addr = 2'd0; reg_wdata = mk(8'hEB, 1, 3'd3, 2'd2, 4'd6, 4'h1);
    rd_req = 1; rd_offset = 24'h000224;
    @(negedge clk); reg_we = 0;
    while (rd_ready !== 1'b1) @(negedge clk);
    rd_req = 0;
    // R9 back-to-back read; shape still the old one (R10)
    cur_tag = "R10 old shape kept";
    do_read(24'h000228, lat);
    // Write honoured once disabled: quad I/O shape takes effect
    cur_tag = "R10 write after disable";
    cfg(8'hEB, 1, 3, 2'd2, 6, 4'h1);
    do_read(24'h000300, lat);

    repeat (10) @(negedge clk);
    chk(sck_bad == 0, "R11 sck high phase length", 64'(sck_bad), 64'd0);
    chk(sb_q.size() == 0, "R8 all reads answered", 64'(sb_q.size()), 64'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule